// File: doc/BRIEF.md
# Differential Clock Output Run/Stop/Power-Down Gating

This block decides, for each of a set of differential clock outputs (four by default), whether that output runs, is stopped, is disabled or is powered down. It combines configuration bits (per-output enable, per-output stop participation, power-down pin polarity, and driven-versus-floating behaviour for stop and power-down) with external pins: one output-enable pin per output, a global active-low stop request and a power-down pin. All pins pass through a two-flop synchronizer before use.

The block derives a reference clock at half the rate of `clk` and produces, for each output, a true leg, a complement leg, a run flag and a tristate select. The per-output state is updated only on edges where the reference is about to go low. As a result, every pulse on a true leg is exactly one `clk` cycle wide, and no output ever produces a shortened pulse.

Top module: `diff_clk_gate`

## Requirements
- R1: An output runs (`out_run`=1) only when both its `cfg_en` bit and its `pin_oe` bit are 1, with power-down and stop inactive. Otherwise it does not run.
- R2: When the stop request is active (`pin_halt_n`=0), an output whose `cfg_stoppable` bit is 1 stops. An output whose bit is 0 keeps running regardless of `pin_halt_n`.
- R3: Power-down is active when `pin_pd`=0 if `cfg_pd_pol`=0, and when `pin_pd`=1 if `cfg_pd_pol`=1.
- R4: A powered-down output has `out_hiz`=`cfg_pd_hiz` (0 = driven, 1 = floating).
- R5: A stopped output has `out_hiz`=`cfg_stop_hiz` (0 = driven, 1 = floating). A disabled or running output always has `out_hiz`=0.
- R6: Power-down takes priority over stop, and stop takes priority over the enable decision. A disabled output that is stoppable still enters the stopped state while the stop request is active.
- R7: A running output toggles its true leg every `clk` cycle. Each high phase lasts exactly one cycle. A change of `out_run` occurs only on an edge where the true leg goes low or stays low.
- R8: Each pin passes through two synchronizing flops. A pin change applied before a clock edge has no effect on the outputs after that edge or after the following edge.
- R9: An output that is not running holds its true leg at 0 and its complement leg at 1. A running output always has its complement leg equal to the inverse of its true leg.
- R10: During and right after reset, every output has `out_run`=0, `out_hiz`=0, true leg 0 and complement leg 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | N_OUT | Per-output enable bit from configuration |
| cfg_stoppable | input | N_OUT | 1 = output obeys the stop request |
| cfg_pd_pol | input | 1 | Power-down pin polarity: 0 active low, 1 active high |
| cfg_pd_hiz | input | 1 | Power-down output behaviour: 0 driven, 1 floating |
| cfg_stop_hiz | input | 1 | Stop output behaviour: 0 driven, 1 floating |
| pin_oe | input | N_OUT | Per-output enable pins, active high |
| pin_halt_n | input | 1 | Global stop request pin, active low |
| pin_pd | input | 1 | Power-down pin, polarity set by `cfg_pd_pol` |
| out_run | output | N_OUT | 1 while the output is running |
| out_hiz | output | N_OUT | 1 selects floating output drivers |
| out_t | output | N_OUT | True leg of each output |
| out_c | output | N_OUT | Complement leg of each output |

## Verification
The assertions assume that `clk` is the only clock and that every pin is sampled only after synchronization. They also assume that the configuration bits are quasi-static with respect to the output state. The stimulus therefore changes pins and configuration only on falling `clk` edges. It then holds them for ten cycles before checking, so that both synchronizer stages and at least one reference-low update edge have elapsed. The sync-latency case is the one exception: it checks on purpose inside the two-cycle window that follows a pin change.

// File: rtl/gate_pkg.sv
package gate_pkg;

    typedef enum logic [1:0] {
        MODE_DIS  = 2'd0,
        MODE_RUN  = 2'd1,
        MODE_STOP = 2'd2,
        MODE_PDN  = 2'd3
    } mode_e;

    // Priority: power-down, then stop, then enable permission.
    function automatic mode_e pick_mode(input logic pd_act,
                                        input logic halt_act,
                                        input logic stoppable,
                                        input logic en,
                                        input logic oe);
        if (pd_act)
            return MODE_PDN;
        else if (halt_act && stoppable)
            return MODE_STOP;
        else if (en && oe)
            return MODE_RUN;
        else
            return MODE_DIS;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++)
            stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stg_q <= '0;
        else
            stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/out_arbiter.sv
module out_arbiter #(
    parameter int N_OUT = 4
) (
    input  logic                          pd_act,
    input  logic                          halt_act,
    input  logic [N_OUT-1:0]              en,
    input  logic [N_OUT-1:0]              oe,
    input  logic [N_OUT-1:0]              stoppable,
    output gate_pkg::mode_e [N_OUT-1:0]   mode_o
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_arb
        assign mode_o[i] = gate_pkg::pick_mode(pd_act, halt_act,
                                               stoppable[i], en[i], oe[i]);
    end
endmodule

// File: rtl/diff_clk_gate.sv
module diff_clk_gate #(
    parameter int N_OUT       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] cfg_en,
    input  logic [N_OUT-1:0] cfg_stoppable,
    input  logic             cfg_pd_pol,
    input  logic             cfg_pd_hiz,
    input  logic             cfg_stop_hiz,
    input  logic [N_OUT-1:0] pin_oe,
    input  logic             pin_halt_n,
    input  logic             pin_pd,
    output logic [N_OUT-1:0] out_run,
    output logic [N_OUT-1:0] out_hiz,
    output logic [N_OUT-1:0] out_t,
    output logic [N_OUT-1:0] out_c
);
    import gate_pkg::*;

    localparam int PIN_W = N_OUT + 2;

    typedef struct packed {
        logic                ref_clk;
        mode_e [N_OUT-1:0]   mode;
        logic [N_OUT-1:0]    run;
        logic [N_OUT-1:0]    hiz;
        logic [N_OUT-1:0]    t;
        logic [N_OUT-1:0]    c;
    } state_t;

    state_t st_d, st_q;

    logic [PIN_W-1:0]    pins_raw, pins_s;
    logic [N_OUT-1:0]    oe_s;
    logic                halt_s, pd_s, pd_act, halt_act;
    mode_e [N_OUT-1:0]   arb_mode;

    assign pins_raw = {pin_pd, pin_halt_n, pin_oe};

    pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    assign oe_s     = pins_s[N_OUT-1:0];
    assign halt_s   = pins_s[N_OUT];
    assign pd_s     = pins_s[N_OUT+1];
    assign pd_act   = cfg_pd_pol ? pd_s : ~pd_s;
    assign halt_act = ~halt_s;

    out_arbiter #(.N_OUT(N_OUT)) u_arb (
        .pd_act   (pd_act),
        .halt_act (halt_act),
        .en       (cfg_en),
        .oe       (oe_s),
        .stoppable(cfg_stoppable),
        .mode_o   (arb_mode)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ref_clk = ~st_q.ref_clk;
        for (int i = 0; i < N_OUT; i++) begin
            // Commit a new mode only when the reference falls next.
            if (st_q.ref_clk)
                st_d.mode[i] = arb_mode[i];
            st_d.run[i] = (st_d.mode[i] == MODE_RUN);
            st_d.hiz[i] = ((st_d.mode[i] == MODE_PDN)  && cfg_pd_hiz) ||
                          ((st_d.mode[i] == MODE_STOP) && cfg_stop_hiz);
            st_d.t[i]   = st_d.ref_clk && st_d.run[i];
            st_d.c[i]   = ~(st_d.ref_clk && st_d.run[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.mode    <= {N_OUT{MODE_DIS}};
            st_q.c       <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_run = st_q.run;
    assign out_hiz = st_q.hiz;
    assign out_t   = st_q.t;
    assign out_c   = st_q.c;

    for (genvar i = 0; i < N_OUT; i++) begin : g_chk
        assert_full_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_t[i]) |=> $fell(out_t[i]));
        assert_change_on_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(out_run[i]) |-> ($past(st_q.ref_clk) && !out_t[i]));
        assert_true_needs_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_t[i] |-> out_run[i]);
        assert_float_not_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_hiz[i] |-> !out_run[i]);
        assert_idle_legs_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !out_run[i] |-> (!out_t[i] && out_c[i]));
    end
endmodule

// File: tb/diff_clk_gate_tb.sv
module diff_clk_gate_tb;
    localparam int N          = 4;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cfg_en = '0, cfg_stoppable = '0, pin_oe = '0;
    logic         cfg_pd_pol = 1'b0, cfg_pd_hiz = 1'b0, cfg_stop_hiz = 1'b0;
    logic         pin_halt_n = 1'b1, pin_pd = 1'b1;
    logic [N-1:0] out_run, out_hiz, out_t, out_c;

    int n_vec = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    diff_clk_gate #(.N_OUT(N)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_stoppable(cfg_stoppable),
        .cfg_pd_pol(cfg_pd_pol), .cfg_pd_hiz(cfg_pd_hiz), .cfg_stop_hiz(cfg_stop_hiz),
        .pin_oe(pin_oe), .pin_halt_n(pin_halt_n), .pin_pd(pin_pd),
        .out_run(out_run), .out_hiz(out_hiz), .out_t(out_t), .out_c(out_c)
    );

    // 0 disabled, 1 running, 2 stopped, 3 powered down
    function automatic int exp_mode(int i);
        logic pd_on;
        pd_on = cfg_pd_pol ? pin_pd : !pin_pd;
        if (pd_on) return 3;
        if (!pin_halt_n && cfg_stoppable[i]) return 2;
        if (cfg_en[i] && pin_oe[i]) return 1;
        return 0;
    endfunction

    function automatic logic exp_hiz(int m);
        return (m == 3) ? cfg_pd_hiz : (m == 2) ? cfg_stop_hiz : 1'b0;
    endfunction

    task automatic check(string req, int i, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s out%0d actual=%0h expected=%0h", req, i, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Checks run/hiz and two consecutive leg samples for every output.
    task automatic check_all(string req);
        logic [N-1:0] t0, c0;
        for (int i = 0; i < N; i++) begin
            int m;
            m = exp_mode(i);
            check(req, i, {7'd0, out_run[i]}, {7'd0, (m == 1)});
            check(req, i, {7'd0, out_hiz[i]}, {7'd0, exp_hiz(m)});
        end
        t0 = out_t; c0 = out_c;
        wait_cyc(1);
        for (int i = 0; i < N; i++) begin
            if (exp_mode(i) == 1)
                check({req, "/R9"}, i, {4'd0, t0[i], c0[i], out_t[i], out_c[i]},
                      {4'd0, t0[i], !t0[i], !t0[i], t0[i]});
            else
                check({req, "/R9"}, i, {4'd0, t0[i], c0[i], out_t[i], out_c[i]},
                      8'b0000_0101);
        end
    endtask

    task automatic settle_check(string req);
        wait_cyc(10);
        check_all(req);
    endtask

    initial begin
        while (!done && cyc < MAX_CYC) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, MAX_CYC);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R10: reset state
        wait_cyc(3);
        for (int i = 0; i < N; i++)
            check("R10", i, {4'd0, out_run[i], out_hiz[i], out_t[i], out_c[i]}, 8'b0000_0001);
        rst_n = 1'b1;
        wait_cyc(1);
        for (int i = 0; i < N; i++)
            check("R10", i, {4'd0, out_run[i], out_hiz[i], out_t[i], out_c[i]}, 8'b0000_0001);

        // R1: enable needs both register and pin; pd pin high = inactive at pol 0
        cfg_en = 4'b1011; pin_oe = 4'b0111;
        settle_check("R1");

        // R7: pulse width over a longer window on a running output
        for (int k = 0; k < 8; k++) begin
            logic a;
            a = out_t[0];
            wait_cyc(1);
            check("R7", 0, {7'd0, out_t[0]}, {7'd0, !a});
        end

        // R2: stop with mixed participation, driven then floating
        cfg_en = 4'b1111; pin_oe = 4'b1111; cfg_stoppable = 4'b0101;
        settle_check("R2");
        // R8: halt not visible within two edges of the pin change
        pin_halt_n = 1'b0;
        wait_cyc(2);
        check("R8", 0, {7'd0, out_run[0]}, 8'd1);
        settle_check("R2");
        cfg_stop_hiz = 1'b1;
        settle_check("R5");

        // R6: stop wins over disable; pd wins over stop
        cfg_en = 4'b0000;
        settle_check("R6");
        pin_pd = 1'b0;
        settle_check("R6");
        cfg_pd_hiz = 1'b1;
        settle_check("R4");

        // R3: flip polarity, pd pin low now means not powered down
        cfg_pd_pol = 1'b1;
        settle_check("R3");
        pin_pd = 1'b1;
        settle_check("R3");
        pin_halt_n = 1'b1; pin_pd = 1'b0; cfg_en = 4'b1111;
        settle_check("R3");

        // Random mix
        for (int r = 0; r < 60; r++) begin
            cfg_en        = N'($urandom);
            cfg_stoppable = N'($urandom);
            pin_oe        = N'($urandom);
            cfg_pd_pol    = 1'($urandom);
            cfg_pd_hiz    = 1'($urandom);
            cfg_stop_hiz  = 1'($urandom);
            pin_halt_n    = ($urandom % 3) != 0;
            pin_pd        = 1'($urandom);
            settle_check("R6");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule